// File: doc/BRIEF.md
# Fractional-Rate Oversampling Serial Receiver

This block receives asynchronous serial characters at any bit rate from 1 bps up to 1 Mbps. Its 16x oversampling tick is the carry of a 32-bit phase accumulator. The accumulator advances by a programmed increment on every system clock, so the bit rate is not limited to integer divisions of the clock. Rates that are not multiples of 9600 keep an average error far below 0.1 percent. The increment is 16 × baud × 2^32 / f_clk.

The serial input first passes through a two-flop synchroniser. A falling edge on the idle line starts a frame. The receiver checks the start bit at its centre, 8 ticks after the edge. It then reads each later bit every 16 ticks, so every bit is taken at its middle. Data bits arrive least significant first. There can be 5 to 8 of them, and an optional parity bit may sit in front of the stop bit. A high stop bit delivers the character with a one-cycle valid strobe. A low stop bit raises a one-cycle framing-error strobe instead. After a framing error the receiver waits for a full bit time of high line before it accepts a new start.

Top module: `uart_frac_rx`

## Requirements
- R1: The oversample tick is the carry out of a 32-bit accumulator that adds `phase_inc` on every clock. The average tick rate is f_clk × phase_inc / 2^32. If `phase_inc` is below 2^31, the tick never appears on two clocks in a row.
- R2: Reception starts when the synchronised line is seen low while the receiver is idle. The line passes through two flip-flops, which reset high.
- R3: The start bit is sampled on the 8th tick after reception starts. If the line is high at that sample, the start counts as a glitch: the receiver returns to idle and emits no strobe.
- R4: Data bits are taken least significant bit first, one every 16 ticks. `cfg_width` selects the count: code 0, 1, 2 and 3 give 5, 6, 7 and 8 bits. The character is right-aligned in `rx_data`, and the unused upper bits are zero.
- R5: The stop bit is sampled 16 ticks after the last data or parity sample. For 8 data bits without parity, that is 152 ticks after reception starts. A high stop bit gives a `rx_valid` pulse one clock wide, with `rx_data` holding the character.
- R6: A low stop bit gives a `frame_err` pulse one clock wide and no `rx_valid`. The two strobes are never high together.
- R7: When `cfg_parity` is 1, one extra bit is sampled between the data and the stop bit. Its value is neither checked nor placed in `rx_data`.
- R8: After a framing error, the line must stay high for 16 consecutive ticks before a new start is accepted. A line held low keeps the receiver waiting and produces no further strobe.
- R9: While and right after `rst` is high, `rx_valid` and `frame_err` are 0 and `rx_data` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| phase_inc | input | 32 | Accumulator increment per clock, 16 × baud × 2^32 / f_clk |
| cfg_width | input | 2 | Data bit count code: 0..3 gives 5..8 bits |
| cfg_parity | input | 1 | 1 = a parity bit precedes the stop bit |
| rx_data | output | 8 | Received character, right-aligned |
| rx_valid | output | 1 | One-cycle strobe: character with good stop bit |
| frame_err | output | 1 | One-cycle strobe: stop bit sampled low |

## Verification
The bench builds the block with its default parameters: 8-bit data, 16x oversampling and a 32-bit accumulator. For most frames the increment is 2^30, which gives one tick every 4 clocks and a 64-clock bit. That short bit makes random frames over all widths and parity settings cheap. It also lets the test move a stop-bit edge to either side of the sampling centre. A fractional increment of 2^32/5.5, which gives an 88-clock bit, shows that a tick period that is not an integer number of clocks still decodes correctly. A long break on the line confirms that framing-error recovery holds the receiver off.

// File: rtl/uart_frac_rx_pkg.sv
package uart_frac_rx_pkg;

    localparam int DATA_W   = 8;
    localparam int OS_RATE  = 16;
    localparam int ACC_W    = 32;
    localparam int MIN_BITS = DATA_W - 3;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PARITY,
        RX_STOP,
        RX_RECOVER
    } rx_state_t;

    typedef struct packed {
        logic [1:0] width_code;
        logic       parity_en;
    } rx_cfg_t;

    function automatic int bits_of(input logic [1:0] code);
        return MIN_BITS + int'(code);
    endfunction

endpackage

// File: rtl/uart_frac_tick.sv
module uart_frac_tick #(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ACC_W-1:0] inc,
    output logic             tick
);
    logic [ACC_W-1:0] acc;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc  <= '0;
            tick <= 1'b0;
        end else begin
            {tick, acc} <= {1'b0, acc} + {1'b0, inc};
        end
    end
endmodule

// File: rtl/uart_line_sync.sv
module uart_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) pipe <= '1;
        else     pipe <= {pipe[STAGES-2:0], din};
    end

    assign dout = pipe[STAGES-1];
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
    import uart_frac_rx_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int OS = OS_RATE
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          rxd,
    input  rx_cfg_t       cfg,
    output logic [DW-1:0] data,
    output logic          valid,
    output logic          ferr
);
    localparam int CNT_W = $clog2(OS);
    localparam int BIT_W = $clog2(DW);
    localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(OS - 1);
    localparam logic [CNT_W-1:0] MID_TICK  = CNT_W'(OS / 2 - 1);

    rx_state_t        state;
    logic [CNT_W-1:0] cnt;
    logic [BIT_W-1:0] bitn;
    logic [DW-1:0]    shreg;
    logic [BIT_W-1:0] last_bit;
    logic [DW-1:0]    aligned;

    always_comb begin
        last_bit = BIT_W'(bits_of(cfg.width_code) - 1);
        aligned  = shreg >> (DW - bits_of(cfg.width_code));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= RX_IDLE;
            cnt   <= '0;
            bitn  <= '0;
            shreg <= '0;
            data  <= '0;
            valid <= 1'b0;
            ferr  <= 1'b0;
        end else begin
            valid <= 1'b0;
            ferr  <= 1'b0;
            case (state)
                RX_IDLE: begin
                    cnt  <= '0;
                    bitn <= '0;
                    if (!rxd) state <= RX_START;
                end
                RX_START: if (tick) begin
                    if (cnt == MID_TICK) begin
                        cnt   <= '0;
                        state <= rxd ? RX_IDLE : RX_DATA;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_DATA: if (tick) begin
                    if (cnt == LAST_TICK) begin
                        cnt   <= '0;
                        shreg <= {rxd, shreg[DW-1:1]};
                        if (bitn == last_bit) begin
                            bitn  <= '0;
                            state <= cfg.parity_en ? RX_PARITY : RX_STOP;
                        end else begin
                            bitn <= bitn + 1'b1;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_PARITY: if (tick) begin
                    if (cnt == LAST_TICK) begin
                        cnt   <= '0;
                        state <= RX_STOP;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_STOP: if (tick) begin
                    if (cnt == LAST_TICK) begin
                        cnt <= '0;
                        if (rxd) begin
                            valid <= 1'b1;
                            data  <= aligned;
                            state <= RX_IDLE;
                        end else begin
                            ferr  <= 1'b1;
                            state <= RX_RECOVER;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_RECOVER: begin
                    if (!rxd) begin
                        cnt <= '0;
                    end else if (tick) begin
                        if (cnt == LAST_TICK) begin
                            cnt   <= '0;
                            state <= RX_IDLE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                default: state <= RX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/uart_frac_rx.sv
module uart_frac_rx
    import uart_frac_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_line,
    input  logic [ACC_W-1:0]  phase_inc,
    input  logic [1:0]        cfg_width,
    input  logic              cfg_parity,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              frame_err
);
    logic    base_tick;
    logic    line_s;
    rx_cfg_t cfg;

    assign cfg = '{width_code: cfg_width, parity_en: cfg_parity};

    uart_frac_tick #(.ACC_W(ACC_W)) i_tick (
        .clk (clk),
        .rst (rst),
        .inc (phase_inc),
        .tick(base_tick)
    );

    uart_line_sync #(.STAGES(2)) i_sync (
        .clk (clk),
        .rst (rst),
        .din (rx_line),
        .dout(line_s)
    );

    uart_rx_frame #(.DW(DATA_W), .OS(OS_RATE)) i_frame (
        .clk  (clk),
        .rst  (rst),
        .tick (base_tick),
        .rxd  (line_s),
        .cfg  (cfg),
        .data (rx_data),
        .valid(rx_valid),
        .ferr (frame_err)
    );
endmodule

// File: rtl/uart_frac_rx_chk.sv
module uart_frac_rx_chk
    import uart_frac_rx_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              tick,
    input logic [ACC_W-1:0]  phase_inc,
    input logic [1:0]        cfg_width,
    input logic [DATA_W-1:0] rx_data,
    input logic              rx_valid,
    input logic              frame_err
);
    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
        (tick && !phase_inc[ACC_W-1] && $stable(phase_inc)) |=> (!tick || phase_inc != $past(phase_inc))); // R1

    AST_DATA_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> ((rx_data >> bits_of(cfg_width)) == '0)); // R4

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid); // R5

    AST_FERR_PULSE: assert property (@(posedge clk) disable iff (rst)
        frame_err |=> !frame_err); // R6

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(rx_valid && frame_err)); // R6

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!rx_valid && !frame_err && rx_data == '0)); // R9
endmodule

bind uart_frac_rx uart_frac_rx_chk i_chk (
    .clk      (clk),
    .rst      (rst),
    .tick     (base_tick),
    .phase_inc(phase_inc),
    .cfg_width(cfg_width),
    .rx_data  (rx_data),
    .rx_valid (rx_valid),
    .frame_err(frame_err)
);

// File: tb/test_uart_frac_rx.sv
`timescale 1ns/1ps
module test_uart_frac_rx;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rxl = 1'b1;
    logic [31:0] inc = 32'h4000_0000;
    logic [1:0]  cw  = 2'd3;
    logic        cp  = 1'b0;
    logic [7:0]  rx_data;
    logic        rx_valid;
    logic        frame_err;

    int checks = 0;
    int fails  = 0;
    int nv = 0;
    int nf = 0;
    logic [7:0] last_data = 8'h00;
    int bitclk = 64;
    bit done = 1'b0;

    always #5 clk = ~clk;

    uart_frac_rx i_uart_frac_rx (
        .clk(clk), .rst(rst), .rx_line(rxl), .phase_inc(inc),
        .cfg_width(cw), .cfg_parity(cp),
        .rx_data(rx_data), .rx_valid(rx_valid), .frame_err(frame_err)
    );

    always @(posedge clk) begin
        if (!rst) begin
            if (rx_valid) begin
                nv <= nv + 1;
                last_data <= rx_data;
            end
            if (frame_err) nf <= nf + 1;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic hold(input int clks);
        repeat (clks) @(negedge clk);
    endtask

    function automatic logic [7:0] expect_data(input logic [7:0] d, input logic [1:0] code);
        int nb = 5 + int'(code);
        return d & 8'((1 << nb) - 1);
    endfunction

    // stop_low: number of clocks the stop bit is held low before going high
    task automatic send_frame(input logic [7:0] d, input logic [1:0] code, input bit par_en,
                              input bit par_val, input int stop_low);
        int nb = 5 + int'(code);
        @(negedge clk);
        rxl = 1'b0;
        hold(bitclk);
        for (int i = 0; i < nb; i++) begin
            rxl = d[i];
            hold(bitclk);
        end
        if (par_en) begin
            rxl = par_val;
            hold(bitclk);
        end
        rxl = 1'b0;
        if (stop_low > 0) hold(stop_low);
        rxl = 1'b1;
        if (bitclk > stop_low) hold(bitclk - stop_low);
        hold(2 * bitclk);
    endtask

    task automatic good_frame(input logic [7:0] d, input logic [1:0] code, input bit par_en,
                              input bit par_val, input string tag);
        int v0 = nv;
        int f0 = nf;
        cw = code;
        cp = par_en;
        send_frame(d, code, par_en, par_val, 0);
        check(nv == v0 + 1, {tag, " valid count"}, nv - v0, 1);
        check(nf == f0, {tag, " no ferr"}, nf - f0, 0);
        check(last_data == expect_data(d, code), {tag, " data"}, int'(last_data),
              int'(expect_data(d, code)));
    endtask

    initial begin
        int v0;
        int f0;
        void'($urandom(32'h5EED_0042));
        hold(5);
        // R9: reset state
        check(rx_valid == 1'b0 && frame_err == 1'b0, "R9 strobes in reset", int'(rx_valid), 0);
        check(rx_data == 8'h00, "R9 data in reset", int'(rx_data), 0);
        rst = 1'b0;
        hold(10);
        check(nv == 0 && nf == 0, "R2 idle line no strobe", nv + nf, 0);

        // R2 R4 R5: directed 8N1
        good_frame(8'hA5, 2'd3, 1'b0, 1'b0, "R5 8N1 A5");
        good_frame(8'h01, 2'd3, 1'b0, 1'b0, "R4 lsb first 01");
        good_frame(8'hFF, 2'd0, 1'b0, 1'b0, "R4 5 bits FF");
        // R7: parity bit ignored, both values
        good_frame(8'h3C, 2'd2, 1'b1, 1'b0, "R7 parity 0");
        good_frame(8'h3C, 2'd2, 1'b1, 1'b1, "R7 parity 1");

        // R3: glitch shorter than half a bit
        v0 = nv; f0 = nf;
        @(negedge clk); rxl = 1'b0; hold(8); rxl = 1'b1;
        hold(20 * bitclk);
        check(nv == v0 && nf == f0, "R3 glitch rejected", (nv - v0) + (nf - f0), 0);
        good_frame(8'h5A, 2'd3, 1'b0, 1'b0, "R3 after glitch");

        // R5 R6: stop bit sample point at centre
        cw = 2'd3; cp = 1'b0;
        v0 = nv; f0 = nf;
        send_frame(8'h96, 2'd3, 1'b0, 1'b0, 24);
        check(nv == v0 + 1 && nf == f0, "R5 stop early-low still valid", nv - v0, 1);
        v0 = nv; f0 = nf;
        send_frame(8'h96, 2'd3, 1'b0, 1'b0, 48);
        check(nf == f0 + 1, "R6 stop low at centre ferr", nf - f0, 1);
        check(nv == v0, "R6 no valid on ferr", nv - v0, 0);
        hold(2 * bitclk);

        // R8: long break -> only one ferr, then recovery
        v0 = nv; f0 = nf;
        @(negedge clk); rxl = 1'b0; hold(25 * bitclk);
        check(nf == f0 + 1, "R8 break gives single ferr", nf - f0, 1);
        check(nv == v0, "R8 break no valid", nv - v0, 0);
        rxl = 1'b1; hold(2 * bitclk);
        good_frame(8'hC3, 2'd3, 1'b0, 1'b0, "R8 after recovery");

        // R1: fractional increment, 5.5 clocks per tick, 88-clock bit
        inc = 32'd780903145;
        bitclk = 88;
        hold(4 * bitclk);
        good_frame(8'h6D, 2'd3, 1'b0, 1'b0, "R1 fractional 6D");
        good_frame(8'h12, 2'd1, 1'b1, 1'b1, "R1 fractional 6b par");
        inc = 32'h4000_0000;
        bitclk = 64;
        hold(4 * bitclk);

        // random frames
        for (int k = 0; k < 24; k++) begin
            logic [7:0] d = 8'($urandom);
            logic [1:0] c = 2'($urandom);
            bit pe = 1'($urandom);
            bit pv = 1'($urandom);
            good_frame(d, c, pe, pv, "R4 R7 random");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule